// File: doc/BRIEF.md
# Bandwidth Slot-Table Builder

The block turns a set of per-client slot requests into a full ownership table for a time-sliced memory arbiter with a fixed number of slots. A client that asks for N slots receives entries spread evenly across the table. When a placement falls on a slot that is already taken, it slides forward to the next free one. Active clients that asked for nothing receive one spare slot each, as far as a supplied spare budget allows. Every slot still unowned after that is handed out round-robin among the active clients.

Software or a controller presents the request counts, an active mask and the spare budget, then pulses `start`. The engine takes a snapshot of these inputs and builds the table internally. It then streams every slot out through an indexed write port, one slot per cycle in ascending order, and pulses `done`.

A separate combinational admission check reports whether adding a new request to the currently presented requests would need more slots than the table holds.

Top module: `slot_table_builder`

## Requirements
- R1: After reset, `busy`, `slot_we` and `done` are all 0.
- R2: A `start` pulse seen while idle launches a build, and `busy` is 1 in the following cycle. A `start` seen while `busy` is 1 is ignored: the table produced comes from the inputs captured at the accepted start.
- R3: Clients are placed in ascending index order. Each client's scan begins at slot 0 and its step is 64 divided by its request, using integer division. A request above 64 uses a step of 1. An occupied slot moves the scan forward by one position, and a free slot is claimed and moves the scan forward by the step. The scan ends once the position reaches 64.
- R4: An active client with a zero request claims exactly one slot, the first free slot from position 0, but only while the spare budget is above zero. Each such claim lowers the budget by one.
- R5: A client whose active bit is 0 claims nothing during placement, whatever its request.
- R6: Each slot left free after placement, taken in ascending order, goes to the first active client found by a cyclic search that starts at a pointer. The pointer starts at 0 for each build and, after each fill, becomes the chosen client plus one, wrapping after client 14.
- R7: When no client is active, a free slot receives the pointer value itself, so an all-inactive build yields slot s owned by client s mod 15.
- R8: The table is written out as 64 writes in consecutive cycles with slot indices 0 to 63 in order. `done` is 1 for exactly one cycle, in the cycle right after the write of slot 63.
- R9: `adm_reject` is 1 exactly when the sum of all presented request counts plus `new_req` is greater than 64.
- R10: Every value written on `slot_val` is a valid client index, below 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Build launch strobe, honoured only while idle |
| req_cnt | input | 105 | Slot request per client, 7 bits each, client c at bits [7c+6:7c] |
| active | input | 15 | Active flag per client, bit c for client c |
| spare_cnt | input | 7 | Spare-slot budget for zero-request clients |
| new_req | input | 7 | Candidate request for the admission check |
| adm_reject | output | 1 | Candidate request would overcommit the table |
| busy | output | 1 | A build is in progress |
| slot_we | output | 1 | Slot write strobe |
| slot_idx | output | 6 | Index of the slot being written |
| slot_val | output | 4 | Client that owns the slot being written |
| done | output | 1 | One-cycle pulse after the last slot write |

## Verification
The assertions check the streaming discipline on every cycle. Consecutive writes must carry consecutive indices, `done` is a single pulse that follows the write of slot 63, written owners are always in range, a start seen during a build leaves the captured snapshot untouched, the spare budget never grows during placement, and the round-robin search only ever picks an active client. Whether the placement itself is right cannot be seen by any single-cycle property. That covers step spacing, sliding on collisions, the one-slot grants limited by the budget, skipping of inactive clients and the pointer fallback when no client is active. Only the bench can show it, by comparing each full 64-slot stream against a reference table built from the requirements for directed and random request sets.

// File: rtl/stb_pkg.sv
// Package: shared types of the slot-table builder.
// Assumes: nothing beyond IEEE 1800-2017.
package stb_pkg;

    // Build sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLACE = 2'd1,
        ST_FILL  = 2'd2,
        ST_FIN   = 2'd3
    } stb_state_e;

endpackage

// File: rtl/stb_step_calc.sv
// Module: stb_step_calc
// Computes the placement step for one client: the slot count divided by
// the request, or the full table for a zero request (a single claim).
// Assumes: NUM_SLOTS fits in CNT_W and in POS_W bits.
module stb_step_calc #(
    parameter int NUM_SLOTS = 64,
    parameter int CNT_W     = 7,
    parameter int POS_W     = 7
) (
    input  logic [CNT_W-1:0] req,
    output logic [POS_W-1:0] step
);
    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(NUM_SLOTS);

    logic [CNT_W-1:0] quot;

    // Integer quotient; a zero request maps to a full-table step, and a
    // request larger than the table maps to a step of one
    always_comb begin
        quot = '0;
        if (req == '0) begin
            step = POS_W'(NUM_SLOTS);
        end else begin
            quot = SLOTS_C / req;
            step = (quot == '0) ? POS_W'(1) : POS_W'(quot);
        end
    end
endmodule

// File: rtl/stb_rr_pick.sv
// Module: stb_rr_pick
// Cyclic search for the first active client at or after a base index.
// Assumes: base < NUM_CLIENTS. hit is 0 when no client is active.
module stb_rr_pick #(
    parameter int NUM_CLIENTS = 15,
    parameter int CL_W        = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CLIENTS-1:0] act,
    input  logic [CL_W-1:0]        base,
    output logic [CL_W-1:0]        pick,
    output logic                   hit
);
    // Walk the clients from base with wrap-around and keep the first active one
    always_comb begin
        pick = base;
        hit  = 1'b0;
        for (int k = 0; k < NUM_CLIENTS; k++) begin
            int j;
            j = int'(base) + k;
            if (j >= NUM_CLIENTS) j = j - NUM_CLIENTS;
            if (!hit && act[j]) begin
                hit  = 1'b1;
                pick = CL_W'(j);
            end
        end
    end

    AST_PICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> act[pick]); // R6
endmodule

// File: rtl/stb_admit.sv
// Module: stb_admit
// Admission test: flags a new request that, added to the presented
// requests, would need more slots than the table holds.
// Assumes: requests are unsigned slot counts.
module stb_admit #(
    parameter int NUM_CLIENTS = 15,
    parameter int NUM_SLOTS   = 64,
    parameter int CNT_W       = 7
) (
    input  logic [NUM_CLIENTS*CNT_W-1:0] req_flat,
    input  logic [CNT_W-1:0]             new_req,
    output logic                         reject
);
    localparam int SUM_W = CNT_W + $clog2(NUM_CLIENTS + 2);

    logic [SUM_W-1:0] total;

    // Sum every presented request plus the candidate and compare to capacity
    always_comb begin
        total = SUM_W'(new_req);
        for (int c = 0; c < NUM_CLIENTS; c++) begin
            total = total + SUM_W'(req_flat[c*CNT_W +: CNT_W]);
        end
        reject = (total > SUM_W'(NUM_SLOTS));
    end
endmodule

// File: rtl/slot_table_builder.sv
// Module: slot_table_builder
// Builds an arbiter slot-ownership table from per-client requests: spread
// placement, one spare slot per zero-request client, round-robin gap fill,
// then streams all slots out in ascending order and pulses done.
// Assumes: NUM_SLOTS is a power of two; inputs are captured at start.
module slot_table_builder #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 15
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          start,
    input  logic [NUM_CLIENTS*($clog2(NUM_SLOTS+1))-1:0]  req_cnt,
    input  logic [NUM_CLIENTS-1:0]                        active,
    input  logic [$clog2(NUM_SLOTS+1)-1:0]                spare_cnt,
    input  logic [$clog2(NUM_SLOTS+1)-1:0]                new_req,
    output logic                                          adm_reject,
    output logic                                          busy,
    output logic                                          slot_we,
    output logic [$clog2(NUM_SLOTS)-1:0]                  slot_idx,
    output logic [$clog2(NUM_CLIENTS)-1:0]                slot_val,
    output logic                                          done
);
    import stb_pkg::*;

    localparam int CNT_W  = $clog2(NUM_SLOTS + 1);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int POS_W  = SLOT_W + 1;
    localparam int CL_W   = $clog2(NUM_CLIENTS);
    localparam logic [CL_W-1:0]   LAST_CL   = CL_W'(NUM_CLIENTS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    stb_state_e                   state_q;
    logic [NUM_CLIENTS*CNT_W-1:0] reqs_q;
    logic [NUM_CLIENTS-1:0]       act_q;
    logic [CNT_W-1:0]             spare_q;
    logic [CL_W-1:0]              cl_q;
    logic [POS_W-1:0]             pos_q;
    logic [SLOT_W-1:0]            slot_q;
    logic [CL_W-1:0]              rr_q;
    logic [NUM_SLOTS-1:0]         occ_q;
    logic [CL_W-1:0]              own_q [NUM_SLOTS];

    logic [CNT_W-1:0]  cur_req;
    logic              cur_zero;
    logic              cur_ok;
    logic              pos_end;
    logic [SLOT_W-1:0] pos_slot;
    logic [POS_W-1:0]  step;
    logic [CL_W-1:0]   rr_pick;
    logic              rr_hit;
    logic [CL_W-1:0]   fill_val;

    // Admission check on the live request inputs
    stb_admit #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_admit (
        .req_flat (req_cnt),
        .new_req  (new_req),
        .reject   (adm_reject)
    );

    // Placement step of the client under scan
    stb_step_calc #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .POS_W(POS_W)) u_step (
        .req  (cur_req),
        .step (step)
    );

    // Round-robin owner search for free slots
    stb_rr_pick #(.NUM_CLIENTS(NUM_CLIENTS), .CL_W(CL_W)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act_q),
        .base  (rr_q),
        .pick  (rr_pick),
        .hit   (rr_hit)
    );

    // Decode of the current client and scan position
    always_comb begin
        cur_req  = reqs_q[int'(cl_q)*CNT_W +: CNT_W];
        cur_zero = (cur_req == '0);
        cur_ok   = act_q[cl_q] && (!cur_zero || (spare_q != '0));
        pos_end  = (pos_q >= POS_W'(NUM_SLOTS));
        pos_slot = pos_q[SLOT_W-1:0];
        fill_val = rr_hit ? rr_pick : rr_q;
    end

    assign busy = (state_q != ST_IDLE);

    // Build sequencer: capture, placement scan, fill-and-stream, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            reqs_q   <= '0;
            act_q    <= '0;
            spare_q  <= '0;
            cl_q     <= '0;
            pos_q    <= '0;
            slot_q   <= '0;
            rr_q     <= '0;
            occ_q    <= '0;
            slot_we  <= 1'b0;
            slot_idx <= '0;
            slot_val <= '0;
            done     <= 1'b0;
        end else begin
            slot_we <= 1'b0;
            done    <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        reqs_q  <= req_cnt;
                        act_q   <= active;
                        spare_q <= spare_cnt;
                        occ_q   <= '0;
                        cl_q    <= '0;
                        pos_q   <= '0;
                        slot_q  <= '0;
                        rr_q    <= '0;
                        state_q <= ST_PLACE;
                    end
                end
                ST_PLACE: begin
                    if (!cur_ok || pos_end) begin
                        pos_q <= '0;
                        if (cl_q == LAST_CL) state_q <= ST_FILL;
                        else                 cl_q    <= cl_q + 1'b1;
                    end else if (occ_q[pos_slot]) begin
                        pos_q <= pos_q + 1'b1;
                    end else begin
                        occ_q[pos_slot] <= 1'b1;
                        own_q[pos_slot] <= cl_q;
                        pos_q           <= pos_q + step;
                        if (cur_zero) spare_q <= spare_q - 1'b1;
                    end
                end
                ST_FILL: begin
                    slot_we  <= 1'b1;
                    slot_idx <= slot_q;
                    if (occ_q[slot_q]) begin
                        slot_val <= own_q[slot_q];
                    end else begin
                        slot_val <= fill_val;
                        rr_q     <= (fill_val == LAST_CL) ? '0 : fill_val + 1'b1;
                    end
                    if (slot_q == LAST_SLOT) state_q <= ST_FIN;
                    else                     slot_q  <= slot_q + 1'b1;
                end
                default: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(slot_we) && ($past(slot_idx) == LAST_SLOT))); // R8
    AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_we && $past(slot_we)) |-> (slot_idx == $past(slot_idx) + 1'b1)); // R8
    AST_VAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_we |-> (int'(slot_val) < NUM_CLIENTS)); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(act_q) && $stable(reqs_q))); // R2
    AST_SPARE_NOINC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLACE) |=> (spare_q <= $past(spare_q))); // R4
endmodule

// File: tb/slot_table_builder_tb_top.sv
// Bench for slot_table_builder: directed corners plus seeded random request
// sets, each streamed table compared against a reference built in the bench.
module slot_table_builder_tb_top;
    localparam int NS = 64;
    localparam int NC = 15;
    localparam int CW = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [NC*CW-1:0] req_cnt = '0;
    logic [NC-1:0]    active = '0;
    logic [CW-1:0]    spare_cnt = '0;
    logic [CW-1:0]    new_req = '0;
    logic             adm_reject, busy, slot_we, done;
    logic [5:0]       slot_idx;
    logic [3:0]       slot_val;

    int n_tests = 0;
    int n_fail  = 0;
    int r_req [NC];
    bit [NC-1:0] r_act;
    int r_spare;
    int exp_tbl [NS];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    slot_table_builder #(.NUM_SLOTS(NS), .NUM_CLIENTS(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .req_cnt(req_cnt),
        .active(active), .spare_cnt(spare_cnt), .new_req(new_req),
        .adm_reject(adm_reject), .busy(busy), .slot_we(slot_we),
        .slot_idx(slot_idx), .slot_val(slot_val), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // Reference table from the requirements (R3..R7)
    task automatic build_model();
        int sp, rr;
        sp = r_spare;
        for (int s = 0; s < NS; s++) exp_tbl[s] = -1;
        for (int c = 0; c < NC; c++) begin
            int iv, p;
            if (!r_act[c]) continue;
            if (r_req[c] == 0) begin
                if (sp <= 0) continue;
                sp--;
                iv = NS;
            end else begin
                iv = (r_req[c] > NS) ? 1 : NS / r_req[c];
            end
            p = 0;
            while (p < NS) begin
                if (exp_tbl[p] >= 0) p++;
                else begin exp_tbl[p] = c; p += iv; end
            end
        end
        rr = 0;
        for (int s = 0; s < NS; s++) begin
            if (exp_tbl[s] < 0) begin
                int v;
                bit f;
                v = rr; f = 1'b0;
                for (int k = 0; k < NC; k++) begin
                    int j;
                    j = (rr + k) % NC;
                    if (!f && r_act[j]) begin v = j; f = 1'b1; end
                end
                exp_tbl[s] = v;
                rr = (v + 1) % NC;
            end
        end
    endtask

    task automatic drive_inputs();
        for (int c = 0; c < NC; c++) req_cnt[c*CW +: CW] = CW'(r_req[c]);
        active    = r_act;
        spare_cnt = CW'(r_spare);
    endtask

    // Launch a build, optionally disturb it with a stray start, check the stream
    task automatic run_build(input string tag, input bit stray);
        int n, cyc;
        bit last_seen;
        build_model();
        @(negedge clk);
        drive_inputs();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        n = 0; cyc = 0; last_seen = 1'b0;
        while (!done && cyc < 3000) begin
            if (stray && cyc == 4) begin
                active = ~r_act;
                for (int c = 0; c < NC; c++) req_cnt[c*CW +: CW] = CW'(3);
                start = 1'b1;
            end
            if (stray && cyc == 5) begin
                start = 1'b0;
                drive_inputs();
            end
            if (slot_we) begin
                chk(int'(slot_idx) == n, "R8 slot order", int'(slot_idx), n);
                if (n < NS)
                    chk(int'(slot_val) == exp_tbl[n], tag, int'(slot_val), exp_tbl[n]);
                last_seen = (n == NS - 1);
                n++;
            end else begin
                last_seen = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R8 done seen", int'(done), 1);
        chk(n == NS, "R8 write count", n, NS);
        chk(last_seen, "R8 done follows slot 63", int'(last_seen), 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    endtask

    task automatic clear_set();
        for (int c = 0; c < NC; c++) r_req[c] = 0;
        r_act = '0;
        r_spare = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        chk(slot_we == 1'b0, "R1 slot_we reset", int'(slot_we), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: collisions slide; clients 0 and 1 both ask for 2
        clear_set();
        r_req[0] = 2; r_req[1] = 2; r_req[4] = 5; r_act = 15'b000_0000_0001_0011;
        run_build("R3 spread and slide", 1'b0);

        // R4: three zero-request clients, budget of two
        clear_set();
        r_req[2] = 16; r_act = 15'b000_0001_1100_0100; r_spare = 2;
        run_build("R4 spare grants", 1'b0);

        // R5: inactive client with a large request claims nothing
        clear_set();
        r_req[0] = 32; r_req[6] = 4; r_act = 15'b000_0000_0100_0000;
        run_build("R5 inactive skipped", 1'b0);

        // R6: gaps only, round-robin over a sparse active set
        clear_set();
        r_act = 15'b100_0010_0000_1001;
        run_build("R6 round robin fill", 1'b0);

        // R7: nobody active, slot s owned by s mod 15
        clear_set();
        run_build("R7 no active client", 1'b0);

        // R2: stray start mid-build is ignored; also a request above 64 (R3)
        clear_set();
        r_req[3] = 100; r_req[9] = 3; r_act = 15'b000_0010_0000_1000;
        run_build("R2 stray start ignored", 1'b1);

        // Random request sets
        for (int t = 0; t < 30; t++) begin
            clear_set();
            for (int c = 0; c < NC; c++) begin
                int pick;
                pick = $urandom_range(0, 7);
                r_req[c] = (pick < 3) ? 0 : (pick == 7 ? 16 : pick - 2);
                r_act[c] = ($urandom_range(0, 3) != 0);
            end
            r_spare = $urandom_range(0, 6);
            run_build("R3 R4 R6 random table", t[0]);
        end

        // R9: admission check on live inputs
        for (int t = 0; t < 40; t++) begin
            int sum;
            sum = 0;
            for (int c = 0; c < NC; c++) begin
                r_req[c] = $urandom_range(0, 8);
                sum += r_req[c];
            end
            @(negedge clk);
            drive_inputs();
            new_req = CW'($urandom_range(0, 70));
            if (t == 0) begin
                for (int c = 0; c < NC; c++) req_cnt[c*CW +: CW] = '0;
                sum = 0;
                new_req = CW'(64);
            end
            if (t == 1) begin
                for (int c = 0; c < NC; c++) req_cnt[c*CW +: CW] = '0;
                sum = 0;
                new_req = CW'(65);
            end
            #1;
            chk(adm_reject == ((sum + int'(new_req)) > NS), "R9 admission",
                int'(adm_reject), int'((sum + int'(new_req)) > NS));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule